// File: doc/BRIEF.md
# Correctable Error Address Capture Store

This block sits beside one or more memory ECC checkers and remembers where single-bit errors occurred. Each checker has its own report strobe and an address bus. The source index travels with the address as a tag. Every report is looked up in a small content-addressable store. A location that has not been seen before is written into the lowest-numbered free entry and raises a one-cycle correctable-error event toward the system error aggregator. A location that is already recorded is dropped without any event, so a repeating fault cannot flood the aggregator.

Software uses a word-addressed register port. Through it, software turns event generation on or off, reads and clears the sticky status flags, reads a bitmap of the occupied entries, and reads each entry's source and address. Writing a 1 to an entry's bit in the bitmap word frees that entry, so the same location can be reported again. Reports that arrive together are serialised through a short queue and handled one per cycle. When a report cannot be stored, either because every entry is occupied or because the queue overflows, a sticky overflow flag is set.

Top module: `ecc_fault_cam`

## Requirements
- R1: After reset, every entry is invalid, the enable bit and both status flags read 0, and `event_o` is low.
- R2: A report whose {source, address} key matches no valid entry is written into the lowest-numbered invalid entry. If the enable bit is set, `event_o` is high for exactly the one cycle after the cycle in which the report was handled.
- R3: A report whose key matches a valid entry is discarded. No event is raised and no entry changes. The same address from a different source is a different key.
- R4: The enable bit is bit 0 of word 0. While it is clear, `event_o` stays low and the event status flag is not set, but new keys are still recorded.
- R5: The event status flag is bit 0 of word 1. It is set together with each event pulse and stays set until software writes 1 to that bit.
- R6: Word 2 reads back the valid bitmap, with bit i for entry i. Word 32+i reads entry i as follows: bit 31 is the valid bit, bit 16 is the source index, and bits 15:0 are the address. Read data is available in the cycle after the request.
- R7: Writing 1 to bit i of word 2 invalidates entry i. The same key reported afterwards is recorded again and raises an event.
- R8: When all 32 entries are valid and an unmatched key arrives, the key is not stored. The overflow flag (bit 1 of word 1, write 1 to clear) is set, and the event is still raised.
- R9: Reports that arrive in the same cycle are handled one per cycle. Reports already queued go first, then new reports in order of increasing source index.
- R10: The input queue holds 2 reports. A report that would exceed this capacity is dropped, and the overflow flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rpt_vld_i | input | NUM_SRC | Per-source correctable-error report strobe |
| rpt_addr_i | input | NUM_SRC*ADDR_W | Per-source error address, with source s at bits [s*ADDR_W +: ADDR_W] |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | Register write when high, read when low |
| reg_addr_i | input | REG_AW | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid the cycle after a read request |
| event_o | output | 1 | Correctable-error event pulse to the error aggregator |

## Verification
The hardest situation to reach from the ports is queue overflow. It needs more simultaneous reports than the queue can absorb while the store is still taking one report per cycle. The bench drives both sources with distinct addresses for three cycles in a row. It then counts the event pulses that follow, checks exactly which keys ended up in which entries, and reads back the overflow flag. The full-store case is reached by a sweep that fills all 32 entries one by one, reading back each inserted entry, before the unmatched report that overflows the store.

// File: rtl/ecc_cam_pkg.sv
package ecc_cam_pkg;
  localparam int unsigned REG_CTRL     = 0;
  localparam int unsigned REG_STAT     = 1;
  localparam int unsigned REG_VMAP     = 2;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned STAT_EVT_BIT = 0;
  localparam int unsigned STAT_OVF_BIT = 1;
  localparam int unsigned ENT_VLD_BIT  = 31;
endpackage

// File: rtl/ecc_cam_inq.sv
module ecc_cam_inq #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned KEY_W   = 17,
  parameter int unsigned QDEPTH  = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_SRC-1:0]       rpt_vld_i,
  input  logic [NUM_SRC*KEY_W-1:0] rpt_key_i,
  output logic                     srv_vld_o,
  output logic [KEY_W-1:0]         srv_key_o,
  output logic                     lost_o
);
  localparam int unsigned LW  = QDEPTH + NUM_SRC;
  localparam int unsigned CW  = $clog2(LW + 1);
  localparam int unsigned QCW = $clog2(QDEPTH + 1);

  logic [KEY_W-1:0] q_q   [QDEPTH];
  logic [KEY_W-1:0] q_nxt [QDEPTH];
  logic [QCW-1:0]   q_cnt_q, q_cnt_nxt;
  logic [KEY_W-1:0] lst   [LW];
  logic [CW-1:0]    n, rem;

  // queued entries first, then new reports by ascending source index
  always_comb begin
    for (int j = 0; j < LW; j++) lst[j] = '0;
    for (int j = 0; j < QDEPTH; j++)
      if (CW'(j) < CW'(q_cnt_q)) lst[j] = q_q[j];
    n = CW'(q_cnt_q);
    for (int s = 0; s < NUM_SRC; s++) begin
      if (rpt_vld_i[s]) begin
        for (int j = 0; j < LW; j++)
          if (CW'(j) == n) lst[j] = rpt_key_i[s*KEY_W +: KEY_W];
        n = n + CW'(1);
      end
    end
    srv_vld_o = (n != '0);
    srv_key_o = lst[0];
    rem       = srv_vld_o ? n - CW'(1) : n;
    for (int j = 0; j < QDEPTH; j++) q_nxt[j] = lst[j+1];
    lost_o    = (rem > CW'(QDEPTH));
    q_cnt_nxt = lost_o ? QCW'(QDEPTH) : QCW'(rem);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_cnt_q <= '0;
      for (int j = 0; j < QDEPTH; j++) q_q[j] <= '0;
    end else begin
      q_cnt_q <= q_cnt_nxt;
      for (int j = 0; j < QDEPTH; j++) q_q[j] <= q_nxt[j];
    end
  end

  // R9: a held report is always served in the next cycle
  assert_queue_drains_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_cnt_q != '0) |-> srv_vld_o);
  // R9: any strobe leads to a served report in the same cycle
  assert_strobe_served_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rpt_vld_i) |-> srv_vld_o);
  // R10: loss only happens when the queue is already occupied
  assert_loss_needs_backlog_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> (q_cnt_q != '0));
endmodule

// File: rtl/ecc_cam_store.sv
module ecc_cam_store #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned KEY_W = 17
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   srv_vld_i,
  input  logic [KEY_W-1:0]       srv_key_i,
  input  logic [DEPTH-1:0]       clr_i,
  output logic [DEPTH-1:0]       vld_o,
  output logic [DEPTH*KEY_W-1:0] key_o,
  output logic                   new_fault_o,
  output logic                   full_drop_o
);
  localparam int unsigned IW = $clog2(DEPTH);

  logic [DEPTH-1:0] vld_q;
  logic [KEY_W-1:0] key_q [DEPTH];
  logic [DEPTH-1:0] match;
  logic             hit, full, ins;
  logic [IW-1:0]    free_idx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i]                 = vld_q[i] && (key_q[i] == srv_key_i);
    assign key_o[i*KEY_W +: KEY_W] = key_q[i];
  end

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld_q[i]) free_idx = IW'(i);
  end

  assign hit         = |match;
  assign full        = &vld_q;
  assign new_fault_o = srv_vld_i && !hit;
  assign ins         = new_fault_o && !full;
  assign full_drop_o = new_fault_o && full;
  assign vld_o       = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) key_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins && free_idx == IW'(i)) begin
          vld_q[i] <= 1'b1;
          key_q[i] <= srv_key_i;
        end else if (clr_i[i]) begin
          vld_q[i] <= 1'b0;
        end
      end
    end
  end

  // R3: a known key leaves the store untouched
  assert_hit_no_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srv_vld_i && hit && clr_i == '0) |=> $stable(vld_q));
  // R2: an insertion adds exactly one valid entry
  assert_insert_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins && clr_i == '0) |=> ($countones(vld_q) == $countones($past(vld_q)) + 1));
  // R2: the chosen slot was free and becomes valid
  assert_slot_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins |=> vld_q[$past(free_idx)]);
  // R8: a full store never changes on an unmatched report
  assert_full_no_insert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_drop_o && clr_i == '0) |=> $stable(vld_q));
endmodule

// File: rtl/ecc_cam_regs.sv
module ecc_cam_regs
  import ecc_cam_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned KEY_W  = 17,
  parameter int unsigned REG_AW = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_req_i,
  input  logic                   reg_we_i,
  input  logic [REG_AW-1:0]      reg_addr_i,
  input  logic [31:0]            reg_wdata_i,
  output logic [31:0]            reg_rdata_o,
  input  logic                   new_fault_i,
  input  logic                   ovf_i,
  input  logic [DEPTH-1:0]       vld_i,
  input  logic [DEPTH*KEY_W-1:0] key_i,
  output logic [DEPTH-1:0]       clr_o,
  output logic                   evt_o
);
  localparam int unsigned IW = $clog2(DEPTH);

  logic          en_q, evt_st_q, ovf_st_q, evt_q;
  logic          wr, rd, is_ent;
  logic [IW-1:0] idx;
  logic [31:0]   rd_nxt, rdata_q;
  logic          wr_ctrl, wr_stat, wr_vmap;

  assign wr      = reg_req_i && reg_we_i;
  assign rd      = reg_req_i && !reg_we_i;
  assign is_ent  = reg_addr_i[REG_AW-1];
  assign idx     = reg_addr_i[IW-1:0];
  assign wr_ctrl = wr && !is_ent && reg_addr_i == REG_AW'(REG_CTRL);
  assign wr_stat = wr && !is_ent && reg_addr_i == REG_AW'(REG_STAT);
  assign wr_vmap = wr && !is_ent && reg_addr_i == REG_AW'(REG_VMAP);
  assign clr_o   = wr_vmap ? reg_wdata_i[DEPTH-1:0] : '0;

  always_comb begin
    rd_nxt = '0;
    if (is_ent) begin
      rd_nxt[ENT_VLD_BIT] = vld_i[idx];
      rd_nxt[KEY_W-1:0]   = key_i[idx*KEY_W +: KEY_W];
    end else begin
      unique case (reg_addr_i)
        REG_AW'(REG_CTRL): rd_nxt[CTRL_EN_BIT] = en_q;
        REG_AW'(REG_STAT): begin
          rd_nxt[STAT_EVT_BIT] = evt_st_q;
          rd_nxt[STAT_OVF_BIT] = ovf_st_q;
        end
        REG_AW'(REG_VMAP): rd_nxt[DEPTH-1:0] = vld_i;
        default: rd_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      evt_st_q <= 1'b0;
      ovf_st_q <= 1'b0;
      evt_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      evt_q <= new_fault_i && en_q;
      if (wr_ctrl) en_q <= reg_wdata_i[CTRL_EN_BIT];
      // set wins over a same-cycle clear
      if (new_fault_i && en_q)                     evt_st_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[STAT_EVT_BIT]) evt_st_q <= 1'b0;
      if (ovf_i)                                   ovf_st_q <= 1'b1;
      else if (wr_stat && reg_wdata_i[STAT_OVF_BIT]) ovf_st_q <= 1'b0;
      if (rd) rdata_q <= rd_nxt;
    end
  end

  assign reg_rdata_o = rdata_q;
  assign evt_o       = evt_q;

  // R4: event only when enabled in the preceding cycle
  assert_evt_gated_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> $past(en_q));
  // R2: the event is a single-cycle pulse unless a new fault follows
  assert_evt_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q && !new_fault_i) |=> !evt_q);
  // R5: status follows a pulse
  assert_evt_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> evt_st_q);
  // R5: write-1 clears when no new event coincides
  assert_evt_w1c_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && reg_wdata_i[STAT_EVT_BIT] && !(new_fault_i && en_q)) |=> !evt_st_q);
  // R8: a dropped key is always flagged
  assert_ovf_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_st_q);
endmodule

// File: rtl/ecc_fault_cam.sv
module ecc_fault_cam #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DEPTH   = 32,
  parameter int unsigned QDEPTH  = 2,
  localparam int unsigned SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int unsigned KEY_W  = SRC_W + ADDR_W,
  localparam int unsigned REG_AW = $clog2(DEPTH) + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        rpt_vld_i,
  input  logic [NUM_SRC*ADDR_W-1:0] rpt_addr_i,
  input  logic                      reg_req_i,
  input  logic                      reg_we_i,
  input  logic [REG_AW-1:0]         reg_addr_i,
  input  logic [31:0]               reg_wdata_i,
  output logic [31:0]               reg_rdata_o,
  output logic                      event_o
);
  // DEPTH must be a power of two, at most 32; KEY_W at most 31

  logic [NUM_SRC*KEY_W-1:0] rpt_key;
  logic                     srv_vld, lost, new_fault, full_drop;
  logic [KEY_W-1:0]         srv_key;
  logic [DEPTH-1:0]         vld, clr;
  logic [DEPTH*KEY_W-1:0]   keys;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_key
    assign rpt_key[s*KEY_W +: KEY_W] = {SRC_W'(s), rpt_addr_i[s*ADDR_W +: ADDR_W]};
  end

  ecc_cam_inq #(.NUM_SRC(NUM_SRC), .KEY_W(KEY_W), .QDEPTH(QDEPTH)) u_inq (
    .clk_i, .rst_ni,
    .rpt_vld_i,
    .rpt_key_i (rpt_key),
    .srv_vld_o (srv_vld),
    .srv_key_o (srv_key),
    .lost_o    (lost)
  );

  ecc_cam_store #(.DEPTH(DEPTH), .KEY_W(KEY_W)) u_store (
    .clk_i, .rst_ni,
    .srv_vld_i   (srv_vld),
    .srv_key_i   (srv_key),
    .clr_i       (clr),
    .vld_o       (vld),
    .key_o       (keys),
    .new_fault_o (new_fault),
    .full_drop_o (full_drop)
  );

  ecc_cam_regs #(.DEPTH(DEPTH), .KEY_W(KEY_W), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni,
    .reg_req_i, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .new_fault_i (new_fault),
    .ovf_i       (full_drop || lost),
    .vld_i       (vld),
    .key_i       (keys),
    .clr_o       (clr),
    .evt_o       (event_o)
  );

  // R3: no event without a report served in the cycle before
  assert_evt_has_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_o |-> $past(srv_vld));
endmodule

// File: tb/sim_ecc_fault_cam.sv
module sim_ecc_fault_cam;
  localparam int NS = 2, AW = 16, DEPTH = 32, RAW = 6;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NS-1:0]     rpt_vld_i = '0;
  logic [NS*AW-1:0]  rpt_addr_i = '0;
  logic              reg_req_i = 1'b0, reg_we_i = 1'b0;
  logic [RAW-1:0]    reg_addr_i = '0;
  logic [31:0]       reg_wdata_i = '0;
  logic [31:0]       reg_rdata_o;
  logic              event_o;

  int checks = 0, errors = 0;
  bit done = 0;

  bit          m_vld [DEPTH];
  logic [16:0] m_key [DEPTH];
  bit          m_en = 0, m_evt = 0, m_ovf = 0;
  int          m_last = -1;

  always #2 clk = ~clk;

  ecc_fault_cam u0 (
    .clk_i(clk), .rst_ni, .rpt_vld_i, .rpt_addr_i, .reg_req_i, .reg_we_i,
    .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .event_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic reg_wr(input int a, input logic [31:0] d);
    reg_req_i = 1; reg_we_i = 1; reg_addr_i = RAW'(a); reg_wdata_i = d;
    tick();
    reg_req_i = 0; reg_we_i = 0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] d);
    reg_req_i = 1; reg_we_i = 0; reg_addr_i = RAW'(a);
    tick();
    reg_req_i = 0;
    d = reg_rdata_o;
  endtask

  function automatic bit model(input int src, input logic [15:0] addr);
    logic [16:0] k = {src[0], addr};
    m_last = -1;
    for (int i = 0; i < DEPTH; i++) if (m_vld[i] && m_key[i] == k) return 0;
    for (int i = 0; i < DEPTH; i++)
      if (!m_vld[i]) begin m_vld[i] = 1; m_key[i] = k; m_last = i; break; end
    if (m_last < 0) m_ovf = 1;
    if (m_en) m_evt = 1;
    return m_en;
  endfunction

  function automatic logic [31:0] vmap();
    logic [31:0] v = '0;
    for (int i = 0; i < DEPTH; i++) v[i] = m_vld[i];
    return v;
  endfunction

  task automatic report(input int src, input logic [15:0] addr, input string req);
    bit e = model(src, addr);
    rpt_vld_i[src] = 1; rpt_addr_i[src*AW +: AW] = addr;
    tick();
    rpt_vld_i = '0;
    chk(event_o == e, req, 32'(event_o), 32'(e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int ev;
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_key[i] = '0; end
    repeat (3) tick();
    rst_ni = 1;
    tick();
    // R1
    chk(event_o == 0, "R1 event", 32'(event_o), 0);
    reg_rd(0, d); chk(d == 0, "R1 ctrl", d, 0);
    reg_rd(1, d); chk(d == 0, "R1 status", d, 0);
    reg_rd(2, d); chk(d == 0, "R1 bitmap", d, 0);
    reg_rd(32, d); chk(d == 0, "R1 entry0", d, 0);

    reg_wr(0, 1); m_en = 1;
    // R2 first insert and pulse width
    report(0, 16'hA5A5, "R2 first event");
    tick(); chk(event_o == 0, "R2 pulse one cycle", 32'(event_o), 0);
    reg_rd(32, d); chk(d == 32'h8000_A5A5, "R6 entry0", d, 32'h8000_A5A5);
    // R3 repeat dropped, other source distinct
    report(0, 16'hA5A5, "R3 repeat no event");
    reg_rd(2, d); chk(d == vmap(), "R3 bitmap unchanged", d, vmap());
    report(1, 16'hA5A5, "R3 other source new");
    reg_rd(33, d); chk(d == 32'h8001_A5A5, "R6 entry1 source bit", d, 32'h8001_A5A5);
    // R5
    reg_rd(1, d); chk(d == 32'h1, "R5 sticky set", d, 1);
    reg_wr(1, 32'h1); m_evt = 0;
    reg_rd(1, d); chk(d == 0, "R5 sticky cleared", d, 0);
    // R4
    reg_wr(0, 0); m_en = 0;
    report(0, 16'h1234, "R4 disabled no event");
    reg_rd(2, d); chk(d == vmap(), "R4 still recorded", d, vmap());
    reg_rd(1, d); chk(d == 0, "R4 no sticky", d, 0);
    reg_wr(0, 1); m_en = 1;
    // R7
    reg_wr(2, 32'h2); m_vld[1] = 0;
    reg_rd(2, d); chk(d == vmap(), "R7 entry freed", d, vmap());
    report(1, 16'hA5A5, "R7 re-report event");
    chk(m_last == 1, "R7 lowest free slot", 32'(m_last), 1);
    reg_rd(33, d); chk(d == 32'h8001_A5A5, "R7 entry1 reused", d, 32'h8001_A5A5);
    // R2/R6 fill sweep
    for (int k = 0; k < 29; k++) begin
      report(k[0], 16'h0100 + 16'(k), "R2 fill event");
      reg_rd(32 + m_last, d);
      chk(d == {1'b1, 14'b0, m_key[m_last]}, "R6 fill readback", d, {1'b1, 14'b0, m_key[m_last]});
    end
    reg_rd(2, d); chk(d == 32'hFFFF_FFFF, "R8 store full", d, 32'hFFFF_FFFF);
    // R8
    report(1, 16'hBEEF, "R8 full still event");
    reg_rd(1, d); chk(d == 32'h3, "R8 overflow flag", d, 3);
    reg_rd(2, d); chk(d == 32'hFFFF_FFFF, "R8 nothing evicted", d, 32'hFFFF_FFFF);
    report(0, 16'hA5A5, "R3 known when full");
    reg_wr(1, 32'h3); m_evt = 0; m_ovf = 0;
    reg_rd(1, d); chk(d == 0, "R8 flags w1c", d, 0);
    // clear all
    reg_wr(2, 32'hFFFF_FFFF);
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    reg_rd(2, d); chk(d == 0, "R7 clear all", d, 0);
    // R9 simultaneous
    rpt_vld_i = 2'b11; rpt_addr_i = {16'h2222, 16'h1111};
    tick(); rpt_vld_i = '0;
    chk(event_o == 1, "R9 first served", 32'(event_o), 1);
    tick(); chk(event_o == 1, "R9 queued served", 32'(event_o), 1);
    tick(); chk(event_o == 0, "R9 idle after", 32'(event_o), 0);
    reg_rd(32, d); chk(d == 32'h8000_1111, "R9 src0 first", d, 32'h8000_1111);
    reg_rd(33, d); chk(d == 32'h8001_2222, "R9 src1 second", d, 32'h8001_2222);
    reg_wr(2, 32'h3);
    reg_wr(1, 32'h3);
    // R10 queue overflow
    ev = 0;
    rpt_vld_i = 2'b11; rpt_addr_i = {16'h0A01, 16'h0A00};
    tick(); ev += int'(event_o);
    rpt_addr_i = {16'h0B01, 16'h0B00};
    tick(); ev += int'(event_o);
    rpt_addr_i = {16'h0C01, 16'h0C00};
    tick(); ev += int'(event_o);
    rpt_vld_i = '0;
    for (int c = 0; c < 4; c++) begin tick(); ev += int'(event_o); end
    chk(ev == 5, "R10 five served", 32'(ev), 5);
    reg_rd(2, d); chk(d == 32'h1F, "R10 five stored", d, 32'h1F);
    reg_rd(36, d); chk(d == 32'h8000_0C00, "R10 last kept key", d, 32'h8000_0C00);
    reg_rd(35, d); chk(d == 32'h8001_0B01, "R9 order entry3", d, 32'h8001_0B01);
    reg_rd(1, d); chk(d == 32'h3, "R10 loss flagged", d, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule